// File: doc/BRIEF.md
# Masked 64-bit Register Move Unit

This block executes one data-move operation per request between a comparand register, two mask registers, an external data word and a 16-entry array of 64-bit words. Each array word has its own validity flag. The request arrives already decoded and carries these fields:

- a source operand code
- a destination operand code
- a mask select
- a set-validity option
- an explicit array address
- the external data word

The unit moves the full word in a single operation. On transfers between the array and the comparand it can apply a write mask taken from either mask register. After any move that touches the array, it steps the address register.

Requests use a valid/ready handshake. `req_ready` is low while `rst` is high and for the first cycle after `rst` falls. After that it stays high, so the unit never applies back-pressure. A request is taken on every rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the caller must hold the request fields stable. The register contents, the address register and one read port into the array are brought out so that every move can be observed.

Top module: `mvu_move_unit`

## Requirements
- R1: While `rst` is high, the following are cleared: the comparand, both mask registers, the address register, every array word and every validity flag. `done` and `req_ready` are low during reset, and `req_ready` rises one cycle after `rst` falls.
- R2: Operand codes are 0 comparand, 1 mask register one, 2 mask register two, 3 external word `req_data` (source only), 4 array word at the address register, and 5 array word at `req_addr`. An accepted move copies all 64 source bits into the destination.
- R3: A write mask applies only when one operand is the comparand and the other is an array word. `req_msel` 01 selects mask register one and 10 selects mask register two; 00 and 11 select no mask. Only destination bits whose mask bit is 0 take the source value. Moves between any other pair are never masked.
- R4: When the destination is an array word and `req_set_valid` is 1, that word's validity flag is set. When `req_set_valid` is 0, the flag keeps its previous value.
- R5: When either operand uses code 5, the array word at `req_addr` is used, and the address register is updated from `req_addr` rather than from its old value.
- R6: After a move that involves an array word, the address register becomes its base address stepped per `ar_step`. Code 01 adds one, code 10 subtracts one, and codes 00 and 11 hold the base. The step wraps modulo 16. Moves that involve no array word leave the address register unchanged.
- R7: A move changes no register, array word, validity flag or address register in any of these cases: the source equals the destination, both operands are array words, the source is 6 or 7, or the destination is 3, 6 or 7. `done` still pulses for such a move.
- R8: `done` is high for exactly the one cycle after each accepted request, and the results of that move are visible in the same cycle. With no accepted request, `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_src | input | 3 | Source operand code |
| req_dst | input | 3 | Destination operand code |
| req_msel | input | 2 | Mask select |
| req_set_valid | input | 1 | Set validity of an array destination |
| req_addr | input | 4 | Explicit array address for operand code 5 |
| req_data | input | 64 | External word for source code 3 |
| ar_step | input | 2 | Address register step mode |
| done | output | 1 | One-cycle completion pulse |
| cmp_q | output | 64 | Comparand contents |
| mask1_q | output | 64 | Mask register one contents |
| mask2_q | output | 64 | Mask register two contents |
| ar_q | output | 4 | Address register |
| rd_addr | input | 4 | Observation read address into the array |
| rd_data | output | 64 | Array word at `rd_addr` |
| rd_valid | output | 1 | Validity flag at `rd_addr` |

## Verification
Directed moves cover three kinds of path:

- Plain register-to-register copies, with the mask select set to a non-zero value. These show that masking is confined to array/comparand transfers.
- Masked writes of the comparand into the array and of the array into the comparand. They use mask values whose halves differ, so that a swapped mask or an inverted enable shows up.
- Stepping from address 15 upward and from 0 downward. These separate wrap errors from errors in the choice of base.

A group of same-register, array-to-array and reserved-code moves then shows that nothing changes while `done` still pulses. Several hundred random moves over all codes, masks, step modes and addresses follow, each compared with a model of the requirements.

// File: rtl/mvu_pkg.sv
package mvu_pkg;
  localparam logic [2:0] OPD_CMP    = 3'd0;
  localparam logic [2:0] OPD_MSK1   = 3'd1;
  localparam logic [2:0] OPD_MSK2   = 3'd2;
  localparam logic [2:0] OPD_EXT    = 3'd3;
  localparam logic [2:0] OPD_MEM_AR = 3'd4;
  localparam logic [2:0] OPD_MEM_AT = 3'd5;

  localparam logic [1:0] STEP_INC = 2'b01;
  localparam logic [1:0] STEP_DEC = 2'b10;

  typedef struct packed {
    logic nop;
    logic src_mem;
    logic dst_mem;
    logic explicit_addr;
    logic use_mask;
    logic pick_m1;
    logic pick_m2;
  } mvu_dec_t;

  function automatic logic is_array(input logic [2:0] code);
    return (code == OPD_MEM_AR) || (code == OPD_MEM_AT);
  endfunction
endpackage

// File: rtl/mvu_decode.sv
module mvu_decode
  import mvu_pkg::*;
(
  input  logic [2:0] src,
  input  logic [2:0] dst,
  input  logic [1:0] msel,
  output mvu_dec_t   dec
);
  logic src_ok, dst_ok, s_mem, d_mem;

  always_comb begin
    src_ok = (src <= OPD_MEM_AT);
    dst_ok = (dst <= OPD_MEM_AT) && (dst != OPD_EXT);
    s_mem  = is_array(src);
    d_mem  = is_array(dst);

    dec.src_mem       = s_mem;
    dec.dst_mem       = d_mem;
    dec.nop           = !src_ok || !dst_ok || (src == dst) || (s_mem && d_mem);
    dec.explicit_addr = (src == OPD_MEM_AT) || (dst == OPD_MEM_AT);
    dec.use_mask      = (s_mem && dst == OPD_CMP) || (src == OPD_CMP && d_mem);
    dec.pick_m1       = (msel == 2'b01);
    dec.pick_m2       = (msel == 2'b10);
  end
endmodule

// File: rtl/mvu_mem.sv
module mvu_mem #(
  parameter  int DATA_W = 64,
  parameter  int DEPTH  = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_valid,
  input  logic [AW-1:0]     op_addr,
  output logic [DATA_W-1:0] op_data,
  input  logic [AW-1:0]     obs_addr,
  output logic [DATA_W-1:0] obs_data,
  output logic              obs_valid
);
  logic [DATA_W-1:0] words [DEPTH];
  logic              flags [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DATA_W-1:0] w_q;
    logic              v_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        w_q <= '0;
        v_q <= 1'b0;
      end else if (we && waddr == AW'(i)) begin
        w_q <= wdata;
        if (set_valid) v_q <= 1'b1;
      end
    end
    assign words[i] = w_q;
    assign flags[i] = v_q;
  end

  assign op_data   = words[op_addr];
  assign obs_data  = words[obs_addr];
  assign obs_valid = flags[obs_addr];
endmodule

// File: rtl/mvu_addr.sv
module mvu_addr
  import mvu_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [AW-1:0] base,
  input  logic [1:0]    step,
  output logic [AW-1:0] ar
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);
  logic [AW-1:0] nxt;

  always_comb begin
    unique case (step)
      STEP_INC: nxt = (base == TOP) ? '0 : base + AW'(1);
      STEP_DEC: nxt = (base == '0) ? TOP : base - AW'(1);
      default:  nxt = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      ar <= '0;
    else if (upd) ar <= nxt;
  end
endmodule

// File: rtl/mvu_move_unit.sv
module mvu_move_unit
  import mvu_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int DEPTH  = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_src,
  input  logic [2:0]        req_dst,
  input  logic [1:0]        req_msel,
  input  logic              req_set_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [1:0]        ar_step,
  output logic              done,
  output logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] mask1_q,
  output logic [DATA_W-1:0] mask2_q,
  output logic [AW-1:0]     ar_q,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  mvu_dec_t          dec;
  logic              take, commit;
  logic [AW-1:0]     eff_addr;
  logic [DATA_W-1:0] arr_word, src_word, old_word, wmask, new_word;

  mvu_decode u_dec (.src(req_src), .dst(req_dst), .msel(req_msel), .dec(dec));

  assign take     = req_valid && req_ready;
  assign commit   = take && !dec.nop;
  assign eff_addr = dec.explicit_addr ? req_addr : ar_q;

  always_comb begin
    unique case (req_src)
      OPD_CMP:  src_word = cmp_q;
      OPD_MSK1: src_word = mask1_q;
      OPD_MSK2: src_word = mask2_q;
      OPD_EXT:  src_word = req_data;
      default:  src_word = arr_word;
    endcase
    unique case (req_dst)
      OPD_CMP:  old_word = cmp_q;
      OPD_MSK1: old_word = mask1_q;
      OPD_MSK2: old_word = mask2_q;
      default:  old_word = arr_word;
    endcase
    if (!dec.use_mask)   wmask = '0;
    else if (dec.pick_m1) wmask = mask1_q;
    else if (dec.pick_m2) wmask = mask2_q;
    else                  wmask = '0;
    new_word = (old_word & wmask) | (src_word & ~wmask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      done      <= 1'b0;
      cmp_q     <= '0;
      mask1_q   <= '0;
      mask2_q   <= '0;
    end else begin
      req_ready <= 1'b1;
      done      <= take;
      if (commit && req_dst == OPD_CMP)  cmp_q   <= new_word;
      if (commit && req_dst == OPD_MSK1) mask1_q <= new_word;
      if (commit && req_dst == OPD_MSK2) mask2_q <= new_word;
    end
  end

  mvu_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst(rst),
    .we(commit && dec.dst_mem), .waddr(eff_addr), .wdata(new_word),
    .set_valid(req_set_valid),
    .op_addr(eff_addr), .op_data(arr_word),
    .obs_addr(rd_addr), .obs_data(rd_data), .obs_valid(rd_valid)
  );

  mvu_addr #(.DEPTH(DEPTH)) u_ar (
    .clk(clk), .rst(rst),
    .upd(commit && (dec.src_mem || dec.dst_mem)),
    .base(eff_addr), .step(ar_step), .ar(ar_q)
  );
endmodule

// File: rtl/mvu_move_unit_chk.sv
module mvu_move_unit_chk #(
  parameter  int DATA_W = 64,
  parameter  int DEPTH  = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_src,
  input logic [2:0]        req_dst,
  input logic [1:0]        req_msel,
  input logic              done,
  input logic [DATA_W-1:0] cmp_q,
  input logic [DATA_W-1:0] mask1_q,
  input logic [DATA_W-1:0] mask2_q,
  input logic [AW-1:0]     ar_q
);
  logic acc, src_arr, dst_arr;
  assign acc     = req_valid && req_ready;
  assign src_arr = (req_src == 3'd4) || (req_src == 3'd5);
  assign dst_arr = (req_dst == 3'd4) || (req_dst == 3'd5);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (cmp_q == '0 && mask1_q == '0 && mask2_q == '0 &&
                    ar_q == '0 && !done && !req_ready));

  p_done_after_take_r8: assert property (@(posedge clk) disable iff (rst)
    acc |=> done);

  p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !done);

  p_regs_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !acc |=> ($stable(cmp_q) && $stable(mask1_q) && $stable(mask2_q) && $stable(ar_q)));

  p_ar_regonly_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && !src_arr && !dst_arr) |=> $stable(ar_q));

  p_same_reg_nop_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && req_src == req_dst) |=>
      ($stable(cmp_q) && $stable(mask1_q) && $stable(mask2_q) && $stable(ar_q)));

  p_mask1_protects_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && src_arr && req_dst == 3'd0 && req_msel == 2'b01) |=>
      (((cmp_q ^ $past(cmp_q)) & $past(mask1_q)) == '0));
endmodule

bind mvu_move_unit mvu_move_unit_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_dst(req_dst), .req_msel(req_msel), .done(done),
  .cmp_q(cmp_q), .mask1_q(mask1_q), .mask2_q(mask2_q), .ar_q(ar_q)
);

// File: tb/mvu_move_unit_bench.sv
module mvu_move_unit_bench;
  localparam int DW = 64;
  localparam int DP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_src = '0, req_dst = '0;
  logic [1:0]    req_msel = '0;
  logic          req_set_valid = 1'b0;
  logic [3:0]    req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0]    ar_step = '0;
  logic          done;
  logic [DW-1:0] cmp_q, mask1_q, mask2_q;
  logic [3:0]    ar_q;
  logic [3:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  logic [DW-1:0] m_cmp, m_m1, m_m2;
  logic [DW-1:0] m_mem [DP];
  logic          m_val [DP];
  logic [3:0]    m_ar;

  always #4 clk = ~clk;

  mvu_move_unit u_mvu_move_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_msel(req_msel),
    .req_set_valid(req_set_valid), .req_addr(req_addr), .req_data(req_data),
    .ar_step(ar_step), .done(done), .cmp_q(cmp_q), .mask1_q(mask1_q),
    .mask2_q(mask2_q), .ar_q(ar_q), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] stepped(input logic [3:0] b, input logic [1:0] st);
    if (st == 2'b01) return b + 4'd1;
    if (st == 2'b10) return b - 4'd1;
    return b;
  endfunction

  task automatic move(input logic [2:0] s, input logic [2:0] d, input logic [1:0] ms,
                      input logic v, input logic [3:0] a, input logic [DW-1:0] x,
                      input logic [1:0] st, input string tag);
    logic s_arr, d_arr, quiet;
    logic [3:0] eff;
    logic [DW-1:0] sw, ow, mk, nw;
    @(negedge clk);
    req_src = s; req_dst = d; req_msel = ms; req_set_valid = v;
    req_addr = a; req_data = x; ar_step = st; req_valid = 1'b1;
    s_arr = (s == 3'd4) || (s == 3'd5);
    d_arr = (d == 3'd4) || (d == 3'd5);
    quiet = (s > 3'd5) || (d > 3'd5) || (d == 3'd3) || (s == d) || (s_arr && d_arr);
    eff = ((s == 3'd5) || (d == 3'd5)) ? a : m_ar;
    case (s)
      3'd0: sw = m_cmp;
      3'd1: sw = m_m1;
      3'd2: sw = m_m2;
      3'd3: sw = x;
      default: sw = m_mem[eff];
    endcase
    case (d)
      3'd0: ow = m_cmp;
      3'd1: ow = m_m1;
      3'd2: ow = m_m2;
      default: ow = m_mem[eff];
    endcase
    mk = '0;
    if ((s_arr && d == 3'd0) || (s == 3'd0 && d_arr))
      mk = (ms == 2'b01) ? m_m1 : (ms == 2'b10) ? m_m2 : '0;
    nw = (ow & mk) | (sw & ~mk);
    if (!quiet) begin
      case (d)
        3'd0: m_cmp = nw;
        3'd1: m_m1  = nw;
        3'd2: m_m2  = nw;
        default: begin
          m_mem[eff] = nw;
          if (v) m_val[eff] = 1'b1;
        end
      endcase
      if (s_arr || d_arr) m_ar = stepped(eff, st);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", {tag, " done"}, DW'(done), DW'(1));
    chk(tag, "cmp", cmp_q, m_cmp);
    chk(tag, "mask1", mask1_q, m_m1);
    chk(tag, "mask2", mask2_q, m_m2);
    chk("R6", {tag, " ar"}, DW'(ar_q), DW'(m_ar));
    rd_addr = eff;
    #1;
    chk(tag, "word", rd_data, m_mem[eff]);
    chk("R4", {tag, " valid"}, DW'(rd_valid), DW'(m_val[eff]));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < DP; i++) begin
      rd_addr = 4'(i);
      #0.2;
      chk(req, "sweep word", rd_data, m_mem[i]);
      chk(req, "sweep valid", DW'(rd_valid), DW'(m_val[i]));
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'h1F3A_5C07));
    m_cmp = '0; m_m1 = '0; m_m2 = '0; m_ar = '0;
    for (int i = 0; i < DP; i++) begin m_mem[i] = '0; m_val[i] = 1'b0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", DW'(req_ready), DW'(0));
    chk("R1", "done in reset", DW'(done), DW'(0));
    chk("R1", "cmp", cmp_q, '0);
    chk("R1", "mask1", mask1_q, '0);
    chk("R1", "mask2", mask2_q, '0);
    chk("R1", "ar", DW'(ar_q), '0);
    sweep("R1");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", DW'(req_ready), DW'(1));

    // R2: loads from the external word, full width
    move(3'd3, 3'd0, 2'b01, 1'b0, 4'd0, 64'hA5A5_0F0F_1234_5678, 2'b01, "R2");
    move(3'd3, 3'd1, 2'b00, 1'b0, 4'd0, 64'h0000_0000_FFFF_FFFF, 2'b01, "R2");
    move(3'd3, 3'd2, 2'b00, 1'b0, 4'd0, 64'hFFFF_0000_FFFF_0000, 2'b01, "R2");
    // R5, R4, R6: explicit address 15, set validity, increment wraps to 0
    move(3'd0, 3'd5, 2'b00, 1'b1, 4'd15, '0, 2'b01, "R5");
    // R3: masked comparand to word at AR (0), validity kept, decrement wraps to 15
    move(3'd3, 3'd0, 2'b00, 1'b0, 4'd0, 64'hDEAD_BEEF_CAFE_F00D, 2'b01, "R2");
    move(3'd0, 3'd4, 2'b01, 1'b0, 4'd0, '0, 2'b10, "R3");
    // R3: masked word at AR (15) into comparand with mask two, hold
    move(3'd3, 3'd0, 2'b00, 1'b0, 4'd0, 64'h0123_4567_89AB_CDEF, 2'b00, "R2");
    move(3'd4, 3'd0, 2'b10, 1'b0, 4'd0, '0, 2'b00, "R3");
    // R3: mask select 11 means none
    move(3'd5, 3'd0, 2'b11, 1'b0, 4'd0, '0, 2'b00, "R3");
    // R3: register pair never masked
    move(3'd1, 3'd2, 2'b01, 1'b0, 4'd0, '0, 2'b01, "R3");
    move(3'd3, 3'd1, 2'b00, 1'b0, 4'd0, 64'h00FF_00FF_00FF_00FF, 2'b01, "R2");
    // R7: no-op moves
    move(3'd0, 3'd0, 2'b01, 1'b1, 4'd3, '0, 2'b01, "R7");
    move(3'd4, 3'd5, 2'b00, 1'b1, 4'd3, '0, 2'b01, "R7");
    move(3'd0, 3'd3, 2'b00, 1'b1, 4'd3, '0, 2'b01, "R7");
    move(3'd7, 3'd5, 2'b00, 1'b1, 4'd3, 64'h1, 2'b01, "R7");
    move(3'd0, 3'd6, 2'b00, 1'b1, 4'd3, '0, 2'b01, "R7");
    // R8: no request, no pulse
    @(negedge clk);
    @(negedge clk);
    chk("R8", "idle done", DW'(done), DW'(0));
    chk("R8", "idle cmp", cmp_q, m_cmp);

    // Random moves against the model
    for (int n = 0; n < 400; n++) begin
      move(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), {$urandom, $urandom},
           2'($urandom_range(0, 3)), "R2");
    end
    sweep("R4");

    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule